// File: doc/BRIEF.md
# Prefetch Read FIFO

This block pulls a contiguous region of memory into a local byte queue ahead of the consumer that needs it. After a start command gives a base address and a byte count, the block sends read requests of at most `MAXB` bytes to the memory side. It keeps sending until the whole region has been requested, provided that the queue and the bytes already in flight leave room. Memory answers each request with the tag it was given. Answers may come back in any order. The block still admits the data to the queue strictly in the order the requests were sent.

The consumer asks for 1 to `MAXB` bytes at a time. A request is granted only if that many bytes are already buffered. A stop command ends the current region at once. Reads still in flight are marked so that their data is thrown away when they come back. A drain input holds off any new request and reports when nothing is left outstanding. Two single-cycle event outputs mark the region becoming fully requested and the last outstanding read retiring. New requests go out on their own whenever the conditions allow, so no separate resume command is needed.

Top module: `prefetch_rd_fifo`

## Requirements
- R1: Each memory request asks for min(`MAXB`, end address − next address) bytes at the next address. After each accepted request the next address advances by that size.
- R2: `mem_req_valid` is high only if queue level + bytes pending in flight + the new request size ≤ `DEPTH`.
- R3: At most `SLOTS` requests are outstanding. Tags are handed out in ring order 0, 1, …, `SLOTS`−1, 0, … A tag is reused only after its request has retired.
- R4: Completed requests retire in issue order, one per cycle, on the cycle after the response has been recorded. A finished request behind an unfinished one waits.
- R5: A retiring request that is not cancelled appends its bytes to the queue in address order. `rd_data` carries the oldest granted byte in bits [7:0], with the bytes beyond the granted length zero.
- R6: `fill_start` is obeyed only while `at_eob` is high and `fill_stop` is low. It sets the next address to `fill_addr` and the end address to `fill_addr` + `fill_len`. At other times it is ignored.
- R7: `fill_stop` sets the next address equal to the end address, so `at_eob` is high on the next cycle. It marks every in-flight request cancelled, and those requests still complete and free their slots without writing data. No request is offered in the stop cycle.
- R8: A read of `rd_len` bytes is granted only if the queue level is at least `rd_len`. On the next cycle either `rd_ok` or `rd_fail` pulses. A failed read removes nothing.
- R9: `eob_evt` pulses on the cycle after the request that reaches the end address is accepted. It never pulses because of a stop.
- R10: `idle_evt` pulses on the cycle after the last outstanding request retires, provided no new request was accepted in the same cycle.
- R11: While `drain_req` is high no request is offered. `drained` is high when `drain_req` is high and nothing is outstanding.
- R12: After reset the queue is empty, `at_eob` is high, and no request, grant or event is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_start | input | 1 | Begin a new region |
| fill_addr | input | AW | Region base address |
| fill_len | input | LENW | Region length in bytes |
| fill_stop | input | 1 | End the region and cancel in-flight reads |
| drain_req | input | 1 | Hold off new requests |
| rd_req | input | 1 | Consumer read request |
| rd_len | input | CW | Bytes wanted (1..MAXB) |
| rd_ok | output | 1 | Previous read granted |
| rd_fail | output | 1 | Previous read refused |
| rd_data | output | MAXB*8 | Granted bytes, oldest in the low byte |
| fifo_level | output | LVW | Bytes buffered |
| at_eob | output | 1 | Whole region requested |
| eob_evt | output | 1 | Region just became fully requested |
| idle_evt | output | 1 | Last outstanding read just retired |
| drained | output | 1 | Drain requested and nothing outstanding |
| mem_req_valid | output | 1 | Read request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Request address |
| mem_req_len | output | CW | Request size in bytes |
| mem_req_tag | output | TW | Request slot tag |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_tag | input | TW | Tag of the completed request |
| mem_rsp_data | input | MAXB*8 | Response bytes, lowest address in the low byte |

## Verification
The hardest case to reach is a cancelled read retiring while a newer region's reads sit behind it, with some of those newer reads already answered out of order. Only stopping with reads in flight, restarting at once and letting memory answer late tags first gets the block there. The bench's memory model answers a randomly chosen outstanding tag each cycle and holds back ready on some cycles. The scenario also issues stop followed immediately by start, so that cancelled and live slots mix in the ring. A reference model built from queues predicts every request, grant, byte and event on each cycle.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef logic [7:0] byte_t;

  function automatic int min_int(int a, int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/pf_byte_fifo.sv
module pf_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int MAXB  = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(MAXB + 1),
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     wr_n,
  input  logic [MAXB*8-1:0] wr_data,
  input  logic [CW-1:0]     rd_n,
  output logic [MAXB*8-1:0] rd_data,
  output logic [LVW-1:0]    level
);
  import pf_pkg::*;

  byte_t          mem [DEPTH];
  logic [PW-1:0]  wp, rp;

  // storage: several lanes per cycle, so no reset on the array
  always_ff @(posedge clk) begin
    for (int i = 0; i < MAXB; i++) begin
      if (i < int'(wr_n))
        mem[wp + PW'(i)] <= wr_data[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      rd_data <= '0;
    end else begin
      wp    <= wp + PW'(wr_n);
      rp    <= rp + PW'(rd_n);
      level <= level + LVW'(wr_n) - LVW'(rd_n);
      for (int i = 0; i < MAXB; i++)
        rd_data[i*8 +: 8] <= (i < int'(rd_n)) ? mem[rp + PW'(i)] : 8'h00;
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (int'(level) + int'(wr_n) - int'(rd_n)) <= DEPTH); // R2
  AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    int'(rd_n) <= int'(level)); // R8
endmodule

// File: rtl/pf_slot_ring.sv
module pf_slot_ring #(
  parameter int SLOTS = 4,
  parameter int MAXB  = 4,
  localparam int TW   = $clog2(SLOTS),
  localparam int CW   = $clog2(MAXB + 1),
  localparam int PBW  = $clog2(SLOTS * MAXB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [CW-1:0]     alloc_size,
  output logic [TW-1:0]     alloc_tag,
  input  logic              cancel_all,
  input  logic              rsp_valid,
  input  logic [TW-1:0]     rsp_tag,
  input  logic [MAXB*8-1:0] rsp_data,
  output logic              full,
  output logic [TW:0]       count,
  output logic [PBW-1:0]    pend_bytes,
  output logic              ret,
  output logic [CW-1:0]     head_size,
  output logic              head_cancel,
  output logic [MAXB*8-1:0] head_data
);
  logic [TW:0]       wp, rp;
  logic [SLOTS-1:0]  done_q, canc_q;
  logic [CW-1:0]     size_q [SLOTS];
  logic [MAXB*8-1:0] data_q [SLOTS];
  logic [TW-1:0]     head;

  assign head        = rp[TW-1:0];
  assign count       = wp - rp;
  assign alloc_tag   = wp[TW-1:0];
  assign full        = (count == (TW+1)'(SLOTS));
  assign ret         = (count != '0) && done_q[head];
  assign head_size   = size_q[head];
  assign head_cancel = canc_q[head];
  assign head_data   = data_q[head];

  // per-slot payload, distributed RAM style
  always_ff @(posedge clk) begin
    if (rsp_valid) data_q[rsp_tag]   <= rsp_data;
    if (alloc)     size_q[alloc_tag] <= alloc_size;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp         <= '0;
      rp         <= '0;
      done_q     <= '0;
      canc_q     <= '0;
      pend_bytes <= '0;
    end else begin
      if (cancel_all) canc_q <= '1;
      if (rsp_valid)  done_q[rsp_tag] <= 1'b1;
      if (ret)        rp <= rp + 1'b1;
      if (alloc) begin
        wp                <= wp + 1'b1;
        done_q[alloc_tag] <= 1'b0;
        canc_q[alloc_tag] <= 1'b0;
      end
      pend_bytes <= pend_bytes + (alloc ? PBW'(alloc_size) : '0)
                               - (ret ? PBW'(head_size) : '0);
    end
  end

  AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= SLOTS); // R3
  AST_ALLOC_ROOM: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !full); // R3
  AST_RSP_LIVE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (({1'b0, rsp_tag - head} < count) && !done_q[rsp_tag])); // R4
  AST_PEND_ZERO: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (pend_bytes == '0)); // R2
endmodule

// File: rtl/prefetch_rd_fifo.sv
module prefetch_rd_fifo #(
  parameter int AW    = 32,
  parameter int LENW  = 16,
  parameter int MAXB  = 4,
  parameter int DEPTH = 16,
  parameter int SLOTS = 4,
  localparam int CW   = $clog2(MAXB + 1),
  localparam int LVW  = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(SLOTS),
  localparam int PBW  = $clog2(SLOTS * MAXB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_start,
  input  logic [AW-1:0]     fill_addr,
  input  logic [LENW-1:0]   fill_len,
  input  logic              fill_stop,
  input  logic              drain_req,
  input  logic              rd_req,
  input  logic [CW-1:0]     rd_len,
  output logic              rd_ok,
  output logic              rd_fail,
  output logic [MAXB*8-1:0] rd_data,
  output logic [LVW-1:0]    fifo_level,
  output logic              at_eob,
  output logic              eob_evt,
  output logic              idle_evt,
  output logic              drained,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  output logic [CW-1:0]     mem_req_len,
  output logic [TW-1:0]     mem_req_tag,
  input  logic              mem_rsp_valid,
  input  logic [TW-1:0]     mem_rsp_tag,
  input  logic [MAXB*8-1:0] mem_rsp_data
);
  logic [AW-1:0]     next_q, end_q, remaining;
  logic [CW-1:0]     req_len;
  logic              room, fire, grant;
  logic              full, ret, head_cancel;
  logic [TW:0]       count;
  logic [PBW-1:0]    pend_bytes;
  logic [CW-1:0]     head_size, wr_n, rd_n;
  logic [MAXB*8-1:0] head_data;

  assign remaining = end_q - next_q;
  assign at_eob    = (next_q == end_q);
  assign req_len   = (remaining >= AW'(MAXB)) ? CW'(MAXB) : remaining[CW-1:0];

  always_comb begin
    room  = (int'(fifo_level) + int'(pend_bytes) + int'(req_len)) <= DEPTH;
    grant = rd_req && (int'(fifo_level) >= int'(rd_len));
  end

  assign mem_req_valid = !at_eob && !full && !drain_req && !fill_stop && room;
  assign mem_req_addr  = next_q;
  assign mem_req_len   = req_len;
  assign fire          = mem_req_valid && mem_req_ready;
  assign drained       = drain_req && (count == '0);
  assign wr_n          = (ret && !head_cancel) ? head_size : '0;
  assign rd_n          = grant ? rd_len : '0;

  pf_slot_ring #(.SLOTS(SLOTS), .MAXB(MAXB)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .alloc      (fire),
    .alloc_size (req_len),
    .alloc_tag  (mem_req_tag),
    .cancel_all (fill_stop),
    .rsp_valid  (mem_rsp_valid),
    .rsp_tag    (mem_rsp_tag),
    .rsp_data   (mem_rsp_data),
    .full       (full),
    .count      (count),
    .pend_bytes (pend_bytes),
    .ret        (ret),
    .head_size  (head_size),
    .head_cancel(head_cancel),
    .head_data  (head_data)
  );

  pf_byte_fifo #(.DEPTH(DEPTH), .MAXB(MAXB)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .wr_n   (wr_n),
    .wr_data(head_data),
    .rd_n   (rd_n),
    .rd_data(rd_data),
    .level  (fifo_level)
  );

  // region pointers
  always_ff @(posedge clk) begin
    if (rst) begin
      next_q <= '0;
      end_q  <= '0;
    end else if (fill_stop) begin
      next_q <= end_q;
    end else if (fire) begin
      next_q <= next_q + AW'(req_len);
    end else if (fill_start && at_eob) begin
      next_q <= fill_addr;
      end_q  <= fill_addr + AW'(fill_len);
    end
  end

  // registered consumer status and events
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok    <= 1'b0;
      rd_fail  <= 1'b0;
      eob_evt  <= 1'b0;
      idle_evt <= 1'b0;
    end else begin
      rd_ok    <= grant;
      rd_fail  <= rd_req && !grant;
      eob_evt  <= fire && (AW'(req_len) == remaining);
      idle_evt <= ret && (count == (TW+1)'(1)) && !fire;
    end
  end

  AST_REQ_SIZE: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_len != '0 && int'(mem_req_len) <= MAXB)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (int'(fifo_level) + int'(pend_bytes)) <= DEPTH); // R2
  AST_START_REGION: assert property (@(posedge clk) disable iff (rst)
    (fill_start && at_eob && !fill_stop) |=> (mem_req_addr == $past(fill_addr))); // R6
  AST_STOP_EOB: assert property (@(posedge clk) disable iff (rst)
    fill_stop |=> at_eob); // R7
  AST_RD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_ok && rd_fail)); // R8
  AST_DRAINED_EMPTY: assert property (@(posedge clk) disable iff (rst)
    drained |-> (pend_bytes == '0)); // R11
endmodule

// File: tb/sim_prefetch_rd_fifo.sv
module sim_prefetch_rd_fifo;
  localparam int AW = 32, LENW = 16, MAXB = 4, DEPTH = 16, SLOTS = 4;
  localparam int CW = 3, LVW = 5, TW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic fill_start = 0, fill_stop = 0, drain_req = 0, rd_req = 0;
  logic [AW-1:0] fill_addr = '0;
  logic [LENW-1:0] fill_len = '0;
  logic [CW-1:0] rd_len = '0;
  logic rd_ok, rd_fail, at_eob, eob_evt, idle_evt, drained;
  logic [MAXB*8-1:0] rd_data;
  logic [LVW-1:0] fifo_level;
  logic mem_req_valid, mem_req_ready = 0;
  logic [AW-1:0] mem_req_addr;
  logic [CW-1:0] mem_req_len;
  logic [TW-1:0] mem_req_tag;
  logic mem_rsp_valid = 0;
  logic [TW-1:0] mem_rsp_tag = '0;
  logic [MAXB*8-1:0] mem_rsp_data = '0;

  prefetch_rd_fifo #(.AW(AW), .LENW(LENW), .MAXB(MAXB), .DEPTH(DEPTH), .SLOTS(SLOTS)) u0 (
    .clk(clk), .rst(rst), .fill_start(fill_start), .fill_addr(fill_addr),
    .fill_len(fill_len), .fill_stop(fill_stop), .drain_req(drain_req),
    .rd_req(rd_req), .rd_len(rd_len), .rd_ok(rd_ok), .rd_fail(rd_fail),
    .rd_data(rd_data), .fifo_level(fifo_level), .at_eob(at_eob),
    .eob_evt(eob_evt), .idle_evt(idle_evt), .drained(drained),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_req_tag(mem_req_tag), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state
  typedef struct { int size; bit cancel; bit done; logic [31:0] addr; int tag; } ent_t;
  ent_t pend[$];
  logic [7:0] q_fifo[$];
  logic [AW-1:0] m_next = '0, m_end = '0;
  int m_tag = 0;
  bit e_rd_ok = 0, e_rd_fail = 0, e_eob = 0, e_idle = 0;
  logic [31:0] e_rd_data = '0;
  int e_level = 0;

  function automatic logic [7:0] memb(logic [31:0] a);
    return 8'(a[7:0] * 7 + a[11:8] + 3);
  endfunction

  function automatic int rnd(int n);
    return int'($urandom_range(n - 1, 0));
  endfunction

  task automatic cmp_regs();
    chk("R8", "rd_ok", rd_ok, e_rd_ok);
    chk("R8", "rd_fail", rd_fail, e_rd_fail);
    chk("R5 R4", "rd_data", rd_data, e_rd_data);
    chk("R4 R5 R8", "fifo_level", fifo_level, e_level);
    chk("R9", "eob_evt", eob_evt, e_eob);
    chk("R10", "idle_evt", idle_evt, e_idle);
  endtask

  task automatic step(bit start, logic [31:0] sa, int sl, bit stop, bit drain,
                      int rd_pct, int rdy_pct, int rsp_pct);
    int pb, rl, idx, cands[$], pre_n;
    bit eob, ev, fire, ret, ok;
    logic [31:0] d;
    @(negedge clk);
    if (finished) return;
    cmp_regs();
    fill_start = start; fill_addr = sa; fill_len = LENW'(sl);
    fill_stop = stop; drain_req = drain;
    rd_req = (rnd(100) < rd_pct); rd_len = CW'(1 + rnd(MAXB));
    mem_req_ready = (rnd(100) < rdy_pct);
    cands = {};
    foreach (pend[i]) if (!pend[i].done) cands.push_back(i);
    idx = -1;
    if (cands.size() > 0 && rnd(100) < rsp_pct) idx = cands[rnd(cands.size())];
    mem_rsp_valid = (idx >= 0);
    mem_rsp_tag = '0; mem_rsp_data = '0;
    if (idx >= 0) begin
      mem_rsp_tag = TW'(pend[idx].tag);
      for (int i = 0; i < pend[idx].size; i++)
        mem_rsp_data[i*8 +: 8] = memb(pend[idx].addr + 32'(i));
    end
    #1;
    // combinational outputs against the model
    pb = 0;
    foreach (pend[i]) pb += pend[i].size;
    eob = (m_next == m_end);
    rl = ((m_end - m_next) >= MAXB) ? MAXB : int'(m_end - m_next);
    ev = !eob && pend.size() < SLOTS && !drain && !stop && (q_fifo.size() + pb + rl <= DEPTH);
    chk("R2 R3 R11", "mem_req_valid", mem_req_valid, ev);
    if (ev) begin
      chk("R1", "mem_req_addr", mem_req_addr, m_next);
      chk("R1", "mem_req_len", mem_req_len, rl);
      chk("R3", "mem_req_tag", mem_req_tag, m_tag);
    end
    chk("R6 R7", "at_eob", at_eob, eob);
    chk("R11", "drained", drained, drain && pend.size() == 0);
    // commit model step for the coming edge
    fire = ev && mem_req_ready;
    pre_n = pend.size();
    ret = (pre_n > 0) && pend[0].done;
    ok = rd_req && (q_fifo.size() >= int'(rd_len));
    d = '0;
    if (ok) for (int i = 0; i < int'(rd_len); i++) d[i*8 +: 8] = q_fifo.pop_front();
    e_rd_ok = ok; e_rd_fail = rd_req && !ok; e_rd_data = d;
    if (idx >= 0) pend[idx].done = 1;
    if (ret) begin
      ent_t e = pend.pop_front();
      if (!e.cancel) for (int i = 0; i < e.size; i++) q_fifo.push_back(memb(e.addr + 32'(i)));
    end
    if (stop) foreach (pend[i]) pend[i].cancel = 1;
    e_eob = fire && (rl == int'(m_end - m_next));
    e_idle = ret && pre_n == 1 && !fire;
    if (stop) m_next = m_end;
    else if (fire) begin
      pend.push_back('{size: rl, cancel: 0, done: 0, addr: m_next, tag: m_tag});
      m_tag = (m_tag + 1) % SLOTS;
      m_next = m_next + AW'(rl);
    end else if (start && eob) begin
      m_next = sa; m_end = sa + AW'(sl);
    end
    e_level = q_fifo.size();
  endtask

  task automatic run(int n, bit drain, int rd_pct, int rdy_pct, int rsp_pct);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, drain, rd_pct, rdy_pct, rsp_pct);
  endtask

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R12", "reset fifo_level", fifo_level, 0);
    chk("R12", "reset at_eob", at_eob, 1);
    chk("R12", "reset mem_req_valid", mem_req_valid, 0);
    chk("R12", "reset events", {rd_ok, rd_fail, eob_evt, idle_evt}, 0);
    // aligned region, random consumption
    step(1, 32'h100, 40, 0, 0, 40, 70, 50);
    run(200, 0, 40, 70, 50);
    run(40, 0, 90, 100, 90);
    // unaligned region, stop with reads in flight, immediate restart
    step(1, 32'h203, 37, 0, 0, 20, 100, 20);
    run(6, 0, 20, 100, 20);
    step(0, 0, 0, 1, 0, 20, 100, 20);
    step(1, 32'h300, 9, 0, 0, 20, 100, 40);
    run(150, 0, 50, 60, 40);
    // start while a region is still open is ignored
    step(1, 32'h400, 20, 0, 0, 0, 100, 30);
    run(3, 0, 0, 100, 30);
    step(1, 32'h500, 8, 0, 0, 0, 100, 30);
    run(150, 0, 60, 80, 50);
    // drain during a fill, consumer starved then hungry
    step(1, 32'h607, 30, 0, 0, 0, 100, 30);
    run(5, 0, 0, 100, 30);
    run(30, 1, 0, 100, 60);
    run(150, 0, 70, 50, 50);
    // stop when nothing is outstanding, then a short region
    step(0, 0, 0, 1, 0, 50, 100, 50);
    step(1, 32'h7FE, 3, 0, 0, 50, 100, 50);
    run(60, 0, 80, 100, 60);
    @(negedge clk);
    cmp_regs();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule